// File: doc/BRIEF.md
# Host Command Word Encoder

This block runs on the host end of a byte-wide link to a memory programming device. A client hands it one request at a time over a valid/ready handshake: load a 24-bit address, read a run of words, query status or identity, send a no-op, fill a flash write buffer, or stream a block into pseudo-static RAM. The block expands each request into a fixed series of 16-bit command words. In each word the opcode sits in the low byte and its argument in the high byte. The words leave on a transmit byte stream with the high byte first. Payload words for the two write requests are pulled from a separate write-word port.

On the return path the block pairs bytes from a receive stream into 16-bit response words. The low byte arrives first. Each finished word is presented for one cycle. A read or query expects a known number of response words. After issuing one, the block holds off further requests until that many words have been assembled. A flash request whose length the device cannot take is refused with a one-cycle error pulse, and nothing is sent for it.

Top module: `hostcmd_encoder`

## Requirements
- R1: Every command word is sent as two transmit bytes, the high byte first and then the low byte. A byte stays unchanged on `tx_byte` with `tx_valid` high until `tx_ready` takes it.
- R2: Kind 0 (load address) sends three words with low bytes 0xA0, 0xA1 and 0xA2. Their high bytes carry address bits 7:0, 15:8 and 23:16 of `req_arg`.
- R3: Kind 1 (read) sends the word {count, 0xCD}, with the count taken from `req_arg[7:0]`. It then keeps `req_ready` low until that many response words have been assembled. A count of 0 stands for 65536.
- R4: Kind 2 (query) sends {subcode, 0xC5}, with the subcode taken from `req_arg[7:0]`. It then keeps `req_ready` low until one response word has been assembled.
- R5: Kind 3 (no-op) sends the single word 0x003F and waits for no response.
- R6: Kind 4 (flash buffer write, N = `req_arg[7:0]`) sends these words in order: {N, 0xE8}, then {0x00, N-1}, then N words taken in order from the write-word port, then 0x00D0.
- R7: A kind 4 request with N of 0 or above 16, and any request of kind 6 or 7, is accepted but sends no byte. It raises `req_error` for exactly one cycle, in the cycle after acceptance.
- R8: Kind 5 (block write) sends {N, 0xE9} and then N words from the write-word port, with no closing word. An N of 0 stands for 65536 words.
- R9: Received bytes are paired into words with the first byte of each pair as the low half. `rsp_valid` pulses for one cycle, in the cycle after the second byte is taken, together with the word.
- R10: A synchronous active-low reset drops any word that has been partly sent and any lone received byte. It clears the response wait, so `req_ready` is high and `tx_valid`, `rsp_valid`, `req_error` and `wr_ready` are low after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be accepted |
| req_kind | input | 3 | Request kind code 0..7 |
| req_arg | input | 24 | Address (kind 0) or count/subcode in bits 7:0 |
| wr_valid | input | 1 | Write payload word offered |
| wr_ready | output | 1 | Write payload word taken |
| wr_word | input | 16 | Write payload word |
| tx_valid | output | 1 | Transmit byte valid |
| tx_ready | input | 1 | Transmit byte accepted |
| tx_byte | output | 8 | Transmit byte |
| rx_valid | input | 1 | Receive byte valid |
| rx_byte | input | 8 | Receive byte |
| rsp_valid | output | 1 | Assembled response word valid (one cycle) |
| rsp_word | output | 16 | Assembled response word |
| req_error | output | 1 | One-cycle pulse for a refused request |

## Verification
Each request kind is first driven with directed arguments. Flash lengths 1 and 16 confirm that the length bounds are inclusive. Lengths 0, 17 and 200 and the unused kind codes must produce the error pulse with a silent transmit stream. A seeded random mix of requests then runs while transmit readiness, write-payload validity and receive byte gaps are all randomised. That mix shows whether framing and word order survive back-pressure. The zero counts for read and block write are run for several hundred words and then stopped by reset. Those runs tell a count of 0 treated as 65536 apart from one treated as empty, and they also exercise the reset of a half-sent word and of a lone received byte.

// File: rtl/hce_pkg.sv
package hce_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;
  localparam int SPAN_W = WORD_W + 1;
  localparam int ADDR_W = 3 * BYTE_W;

  localparam logic [2:0] K_ADDR  = 3'd0;
  localparam logic [2:0] K_READ  = 3'd1;
  localparam logic [2:0] K_QUERY = 3'd2;
  localparam logic [2:0] K_NOP   = 3'd3;
  localparam logic [2:0] K_FLASH = 3'd4;
  localparam logic [2:0] K_PSRAM = 3'd5;

  localparam logic [7:0] OPC_ADR0  = 8'hA0;
  localparam logic [7:0] OPC_ADR1  = 8'hA1;
  localparam logic [7:0] OPC_ADR2  = 8'hA2;
  localparam logic [7:0] OPC_READ  = 8'hCD;
  localparam logic [7:0] OPC_QRY   = 8'hC5;
  localparam logic [7:0] OPC_NOP   = 8'h3F;
  localparam logic [7:0] OPC_FBUF  = 8'hE8;
  localparam logic [7:0] OPC_FCONF = 8'hD0;
  localparam logic [7:0] OPC_PBLK  = 8'hE9;

  typedef enum logic [2:0] {
    S_IDLE, S_HDR, S_CNTW, S_DATA, S_CONF
  } seq_state_e;

  function automatic logic [WORD_W-1:0] pack_cmd(input logic [7:0] opc,
                                                  input logic [7:0] arg);
    return {arg, opc};
  endfunction

  function automatic logic [SPAN_W-1:0] span_words(input logic [7:0] n);
    return (n == 8'd0) ? {1'b1, {WORD_W{1'b0}}} : {{(SPAN_W-8){1'b0}}, n};
  endfunction

  function automatic logic flash_len_ok(input logic [7:0] n, input int unsigned maxw);
    return (n != 8'd0) && (32'(n) <= maxw);
  endfunction
endpackage

// File: rtl/hce_tx_ser.sv
module hce_tx_ser
  import hce_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_valid,
  input  logic [WORD_W-1:0] word_in,
  output logic              word_ready,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_byte,
  input  logic              tx_ready
);
  logic              busy;
  logic              lo_phase;
  logic [WORD_W-1:0] hold;
  logic              byte_fire;

  assign word_ready = !busy;
  assign tx_valid   = busy;
  assign tx_byte    = lo_phase ? hold[BYTE_W-1:0] : hold[WORD_W-1:BYTE_W];
  assign byte_fire  = busy && tx_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      lo_phase <= 1'b0;
      hold     <= '0;
    end else if (!busy) begin
      if (word_valid) begin
        busy     <= 1'b1;
        lo_phase <= 1'b0;
        hold     <= word_in;
      end
    end else if (byte_fire) begin
      if (lo_phase) begin
        busy     <= 1'b0;
        lo_phase <= 1'b0;
      end else begin
        lo_phase <= 1'b1;
      end
    end
  end

  // R1
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_byte)));

  // R1
  hi_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && word_ready) |=> (tx_valid && tx_byte == $past(word_in[WORD_W-1:BYTE_W])));

  // R1
  lo_second_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_fire && !lo_phase) |=> (tx_valid && tx_byte == $past(hold[BYTE_W-1:0])));
endmodule

// File: rtl/hce_rsp_asm.sv
module hce_rsp_asm
  import hce_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic              rsp_valid,
  output logic [WORD_W-1:0] rsp_word,
  output logic              word_done
);
  logic              have_lo;
  logic [BYTE_W-1:0] lo_q;

  assign word_done = rx_valid && have_lo;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      have_lo   <= 1'b0;
      lo_q      <= '0;
      rsp_valid <= 1'b0;
      rsp_word  <= '0;
    end else begin
      rsp_valid <= word_done;
      if (rx_valid) begin
        if (have_lo) begin
          rsp_word <= {rx_byte, lo_q};
          have_lo  <= 1'b0;
        end else begin
          lo_q    <= rx_byte;
          have_lo <= 1'b1;
        end
      end
    end
  end

  // R9
  rsp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |=> (rsp_valid && rsp_word[WORD_W-1:BYTE_W] == $past(rx_byte)));

  // R9
  rsp_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !have_lo);
endmodule

// File: rtl/hce_cmd_seq.sv
module hce_cmd_seq
  import hce_pkg::*;
#(
  parameter int unsigned FLASH_MAX = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        req_kind,
  input  logic [ADDR_W-1:0] req_arg,
  output logic              req_ready,
  input  logic              hold_off,
  input  logic              wdata_valid,
  input  logic [WORD_W-1:0] wdata,
  output logic              wdata_ready,
  output logic              word_valid,
  output logic [WORD_W-1:0] word_out,
  input  logic              word_ready,
  output logic              err_flag,
  output logic              rsp_arm,
  output logic [SPAN_W-1:0] rsp_expect
);
  seq_state_e        st;
  logic [2:0]        kind_q;
  logic [ADDR_W-1:0] arg_q;
  logic [1:0]        step;
  logic [SPAN_W-1:0] rem;
  logic              err_q;
  logic              req_fire;
  logic              req_ok;
  logic              word_push;

  assign req_ready = (st == S_IDLE) && !hold_off;
  assign req_fire  = req_valid && req_ready;
  assign err_flag  = err_q;
  assign word_push = word_valid && word_ready;

  always_comb begin
    case (req_kind)
      K_ADDR, K_READ, K_QUERY, K_NOP, K_PSRAM: req_ok = 1'b1;
      K_FLASH: req_ok = flash_len_ok(req_arg[7:0], FLASH_MAX);
      default: req_ok = 1'b0;
    endcase
  end

  always_comb begin
    rsp_arm    = 1'b0;
    rsp_expect = '0;
    if (req_fire && req_ok) begin
      if (req_kind == K_READ) begin
        rsp_arm    = 1'b1;
        rsp_expect = span_words(req_arg[7:0]);
      end else if (req_kind == K_QUERY) begin
        rsp_arm    = 1'b1;
        rsp_expect = span_words(8'd1);
      end
    end
  end

  always_comb begin
    word_valid  = 1'b0;
    word_out    = '0;
    wdata_ready = 1'b0;
    case (st)
      S_HDR: begin
        word_valid = 1'b1;
        case (kind_q)
          K_ADDR: begin
            case (step)
              2'd0:    word_out = pack_cmd(OPC_ADR0, arg_q[7:0]);
              2'd1:    word_out = pack_cmd(OPC_ADR1, arg_q[15:8]);
              default: word_out = pack_cmd(OPC_ADR2, arg_q[23:16]);
            endcase
          end
          K_READ:  word_out = pack_cmd(OPC_READ, arg_q[7:0]);
          K_QUERY: word_out = pack_cmd(OPC_QRY, arg_q[7:0]);
          K_FLASH: word_out = pack_cmd(OPC_FBUF, arg_q[7:0]);
          K_PSRAM: word_out = pack_cmd(OPC_PBLK, arg_q[7:0]);
          default: word_out = pack_cmd(OPC_NOP, 8'h00);
        endcase
      end
      S_CNTW: begin
        word_valid = 1'b1;
        word_out   = pack_cmd(arg_q[7:0] - 8'd1, 8'h00);
      end
      S_DATA: begin
        word_valid  = wdata_valid;
        word_out    = wdata;
        wdata_ready = word_ready;
      end
      S_CONF: begin
        word_valid = 1'b1;
        word_out   = pack_cmd(OPC_FCONF, 8'h00);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      kind_q <= K_NOP;
      arg_q  <= '0;
      step   <= '0;
      rem    <= '0;
      err_q  <= 1'b0;
    end else begin
      err_q <= req_fire && !req_ok;
      case (st)
        S_IDLE: begin
          if (req_fire && req_ok) begin
            st     <= S_HDR;
            kind_q <= req_kind;
            arg_q  <= req_arg;
            step   <= '0;
            rem    <= span_words(req_arg[7:0]);
          end
        end
        S_HDR: begin
          if (word_push) begin
            if (kind_q == K_ADDR && step != 2'd2) step <= step + 2'd1;
            else if (kind_q == K_FLASH)           st   <= S_CNTW;
            else if (kind_q == K_PSRAM)           st   <= S_DATA;
            else                                  st   <= S_IDLE;
          end
        end
        S_CNTW: if (word_push) st <= S_DATA;
        S_DATA: begin
          if (word_push) begin
            rem <= rem - 1'b1;
            if (rem == SPAN_W'(1)) st <= (kind_q == K_FLASH) ? S_CONF : S_IDLE;
          end
        end
        S_CONF: if (word_push) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  // R7
  err_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> (st == S_IDLE && !word_valid));

  // R6
  data_rem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DATA) |-> (rem != '0));

  // R6
  conf_after_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CONF) |-> (kind_q == K_FLASH));
endmodule

// File: rtl/hostcmd_encoder.sv
module hostcmd_encoder
  import hce_pkg::*;
#(
  parameter int unsigned FLASH_MAX = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_kind,
  input  logic [ADDR_W-1:0] req_arg,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [WORD_W-1:0] wr_word,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [BYTE_W-1:0] tx_byte,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic              rsp_valid,
  output logic [WORD_W-1:0] rsp_word,
  output logic              req_error
);
  logic              word_valid;
  logic [WORD_W-1:0] word_bus;
  logic              word_ready;
  logic              word_done;
  logic              rsp_arm;
  logic [SPAN_W-1:0] rsp_expect;
  logic [SPAN_W-1:0] pend;
  logic              hold_off;

  assign hold_off = (pend != '0);

  hce_cmd_seq #(.FLASH_MAX(FLASH_MAX)) seq_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_kind(req_kind), .req_arg(req_arg),
    .req_ready(req_ready), .hold_off(hold_off),
    .wdata_valid(wr_valid), .wdata(wr_word), .wdata_ready(wr_ready),
    .word_valid(word_valid), .word_out(word_bus), .word_ready(word_ready),
    .err_flag(req_error), .rsp_arm(rsp_arm), .rsp_expect(rsp_expect)
  );

  hce_tx_ser ser_i (
    .clk(clk), .rst_n(rst_n),
    .word_valid(word_valid), .word_in(word_bus), .word_ready(word_ready),
    .tx_valid(tx_valid), .tx_byte(tx_byte), .tx_ready(tx_ready)
  );

  hce_rsp_asm asm_i (
    .clk(clk), .rst_n(rst_n),
    .rx_valid(rx_valid), .rx_byte(rx_byte),
    .rsp_valid(rsp_valid), .rsp_word(rsp_word), .word_done(word_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                    pend <= '0;
    else if (rsp_arm)              pend <= rsp_expect;
    else if (word_done && hold_off) pend <= pend - 1'b1;
  end

  // R3
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_off |-> !req_ready);

  // R3
  read_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_kind == K_READ) |=> !req_ready);

  // R4
  query_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_kind == K_QUERY) |=> (pend == SPAN_W'(1)));
endmodule

// File: tb/hostcmd_encoder_tb_top.sv
`timescale 1ns/1ps
module hostcmd_encoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_kind = 3'd0;
  logic [23:0] req_arg = 24'd0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [15:0] wr_word = 16'd0;
  logic        tx_valid;
  logic        tx_ready = 1'b0;
  logic [7:0]  tx_byte;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_byte = 8'd0;
  logic        rsp_valid;
  logic [15:0] rsp_word;
  logic        req_error;

  always #4 clk = ~clk;

  hostcmd_encoder dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_arg(req_arg), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_word(wr_word), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_byte(tx_byte),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .rsp_valid(rsp_valid), .rsp_word(rsp_word),
    .req_error(req_error)
  );

  int checks = 0, fails = 0;
  logic [7:0]  exp_b [0:8191];
  logic [7:0]  got_b [0:8191];
  int en = 0, gn = 0, cmp_pos = 0;
  logic [15:0] exp_r [0:1023];
  logic [15:0] got_r [0:1023];
  int rexp = 0, rn = 0;
  logic [15:0] dvals [0:4095];
  int didx = 0, exp_didx = 0;
  int errs_seen = 0;
  bit tx_hold = 1'b0, wr_en = 1'b0;
  int cyc = 0;
  bit done = 1'b0;

  task automatic finish_up();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog: got cycle %0d expected under 150000", cyc);
      finish_up();
    end
  end

  always @(negedge clk) begin
    tx_ready = !tx_hold && ($urandom % 4 != 0);
    if (tx_valid && tx_ready) begin
      got_b[gn % 8192] = tx_byte;
      gn++;
    end
  end

  always @(negedge clk) begin
    wr_valid = wr_en && ($urandom % 3 != 0);
    wr_word  = dvals[didx % 4096];
    if (wr_valid && wr_ready) didx++;
  end

  always @(negedge clk) begin
    if (rsp_valid) begin
      got_r[rn % 1024] = rsp_word;
      rn++;
    end
    if (req_error) errs_seen++;
  end

  task automatic check(input bit ok, input string tag, input int got, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, expv);
    end
  endtask

  function automatic logic [15:0] cmdw(input logic [7:0] opc, input logic [7:0] a);
    return (16'(a) << 8) | 16'(opc);
  endfunction

  task automatic push_w(input logic [15:0] w);
    exp_b[en % 8192] = w[15:8];
    exp_b[(en + 1) % 8192] = w[7:0];
    en += 2;
  endtask

  task automatic model_req(input logic [2:0] k, input logic [23:0] a);
    logic [7:0] n;
    n = a[7:0];
    case (k)
      3'd0: begin
        push_w(cmdw(8'hA0, a[7:0]));
        push_w(cmdw(8'hA1, a[15:8]));
        push_w(cmdw(8'hA2, a[23:16]));
      end
      3'd1: push_w(cmdw(8'hCD, n));
      3'd2: push_w(cmdw(8'hC5, n));
      3'd3: push_w(16'h003F);
      3'd4: begin
        push_w(cmdw(8'hE8, n));
        push_w(16'(n) - 16'd1);
        for (int i = 0; i < int'(n); i++) begin push_w(dvals[exp_didx % 4096]); exp_didx++; end
        push_w(16'h00D0);
      end
      3'd5: begin
        push_w(cmdw(8'hE9, n));
        for (int i = 0; i < int'(n); i++) begin push_w(dvals[exp_didx % 4096]); exp_didx++; end
      end
      default: ;
    endcase
  endtask

  task automatic issue(input logic [2:0] k, input logic [23:0] a, input bit model);
    forever begin
      @(negedge clk);
      if (req_ready) break;
    end
    req_valid = 1'b1; req_kind = k; req_arg = a;
    if (model) model_req(k, a);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic check_stream(input string tag, input bit exact);
    bit ok;
    int bad_got, bad_exp;
    while (gn < en) @(negedge clk);
    if (exact) repeat (4) @(negedge clk);
    ok = 1'b1; bad_got = 0; bad_exp = 0;
    for (int i = cmp_pos; i < en; i++) begin
      if (ok && got_b[i % 8192] !== exp_b[i % 8192]) begin
        ok = 1'b0; bad_got = int'(got_b[i % 8192]); bad_exp = int'(exp_b[i % 8192]);
      end
    end
    if (ok && exact && gn != en) begin ok = 1'b0; bad_got = gn; bad_exp = en; end
    check(ok, tag, bad_got, bad_exp);
    cmp_pos = en;
  endtask

  task automatic feed_byte(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1; rx_byte = b;
    @(negedge clk);
    rx_valid = 1'b0;
    repeat ($urandom % 3) @(negedge clk);
  endtask

  task automatic respond(input int n, input string tag);
    logic [15:0] w;
    int r0;
    r0 = rexp;
    for (int i = 0; i < n; i++) begin
      w = 16'($urandom);
      exp_r[rexp % 1024] = w; rexp++;
      feed_byte(w[7:0]);
      if (i == n - 1) check(req_ready == 1'b0, {tag, " held before last word"}, req_ready, 0);
      feed_byte(w[15:8]);
    end
    repeat (2) @(negedge clk);
    check(req_ready == 1'b1, {tag, " released after last word"}, req_ready, 1);
    begin
      bit ok; int bg, be;
      ok = (rn == rexp); bg = rn; be = rexp;
      for (int i = r0; i < rexp; i++)
        if (ok && got_r[i % 1024] !== exp_r[i % 1024]) begin
          ok = 1'b0; bg = int'(got_r[i % 1024]); be = int'(exp_r[i % 1024]);
        end
      check(ok, "R9 response assembly", bg, be);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic bad_req(input logic [2:0] k, input logic [7:0] n, input string tag);
    int g0, e0;
    repeat (6) @(negedge clk);
    g0 = gn; e0 = errs_seen;
    issue(k, {16'h0, n}, 1'b0);
    repeat (4) @(negedge clk);
    check(errs_seen == e0 + 1, {tag, " error pulse count"}, errs_seen - e0, 1);
    check(gn == g0 && req_ready, {tag, " no bytes sent"}, gn - g0, 0);
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) dvals[i] = 16'($urandom);
    void'($urandom(32'd7321));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check(req_ready && !tx_valid && !rsp_valid && !req_error && !wr_ready,
          "R10 reset state", {req_ready, tx_valid, rsp_valid, req_error, wr_ready}, 5'b10000);
    wr_en = 1'b1;

    issue(3'd0, 24'hC35A17, 1'b1); check_stream("R2 address words", 1'b1);
    issue(3'd3, 24'h0, 1'b1);      check_stream("R5 no-op word", 1'b1);
    check(req_ready == 1'b1, "R5 no response wait", req_ready, 1);
    issue(3'd2, 24'h00, 1'b1); check_stream("R4 query word", 1'b1); respond(1, "R4 query 00");
    issue(3'd2, 24'hC5, 1'b1); check_stream("R4 query word", 1'b1); respond(1, "R4 query C5");
    issue(3'd1, 24'h05, 1'b1); check_stream("R3 read word", 1'b1);  respond(5, "R3 read 5");
    issue(3'd4, 24'h01, 1'b1); check_stream("R6 flash 1 word", 1'b1);
    issue(3'd4, 24'h10, 1'b1); check_stream("R6 flash 16 words", 1'b1);
    issue(3'd5, 24'h01, 1'b1); check_stream("R8 block 1 word", 1'b1);
    issue(3'd5, 24'h07, 1'b1); check_stream("R8 block 7 words", 1'b1);
    bad_req(3'd4, 8'd0,   "R7 flash 0");
    bad_req(3'd4, 8'd17,  "R7 flash 17");
    bad_req(3'd4, 8'd200, "R7 flash 200");
    bad_req(3'd6, 8'd1,   "R7 kind 6");
    bad_req(3'd7, 8'd1,   "R7 kind 7");

    // random mix
    for (int it = 0; it < 30; it++) begin
      int k; logic [23:0] a;
      k = $urandom % 6;
      a = 24'($urandom);
      case (k)
        1: a[7:0] = 8'(1 + $urandom % 6);
        4: a[7:0] = 8'(1 + $urandom % 16);
        5: a[7:0] = 8'(1 + $urandom % 20);
        default: ;
      endcase
      issue(3'(k), a, 1'b1);
      check_stream("R1 R6 R8 random stream", 1'b1);
      if (k == 1) respond(int'(a[7:0]), "R3 random read");
      if (k == 2) respond(1, "R4 random query");
    end

    // R1 hold and R10 partial word reset
    tx_hold = 1'b1;
    issue(3'd3, 24'h0, 1'b0);
    repeat (3) @(negedge clk);
    check(tx_valid && tx_byte == 8'h00, "R1 high byte first and held", tx_byte, 8'h00);
    repeat (2) @(negedge clk);
    check(tx_valid && tx_byte == 8'h00, "R1 byte stable under back-pressure", tx_byte, 8'h00);
    do_reset();
    check(!tx_valid, "R10 partial word dropped", tx_valid, 0);
    tx_hold = 1'b0;
    en = gn; cmp_pos = gn; exp_didx = didx;
    issue(3'd3, 24'h0, 1'b1); check_stream("R10 clean word after reset", 1'b1);

    // R10 lone received byte dropped
    feed_byte(8'h11);
    do_reset();
    exp_r[rexp % 1024] = 16'h3322; rexp++;
    feed_byte(8'h22); feed_byte(8'h33);
    repeat (2) @(negedge clk);
    check(rn == rexp && got_r[(rn - 1) % 1024] == 16'h3322, "R10 lone rx byte dropped",
          got_r[(rn - 1) % 1024], 16'h3322);

    // R3 count 0 means 65536
    issue(3'd1, 24'h0, 1'b1); check_stream("R3 read zero word", 1'b1);
    begin
      int r0; r0 = rn;
      for (int i = 0; i < 300; i++) begin feed_byte(8'(i)); feed_byte(8'(i >> 8)); end
      repeat (2) @(negedge clk);
      check(rn - r0 == 300 && !req_ready, "R3 zero count still waiting", rn - r0, 300);
      rexp = rn;
    end
    do_reset();
    @(negedge clk);
    check(req_ready == 1'b1, "R10 reset clears response wait", req_ready, 1);

    // R8 count 0 means 65536
    exp_didx = didx; en = gn; cmp_pos = gn;
    issue(3'd5, 24'h0, 1'b1);
    begin
      int d0, g0;
      d0 = didx; g0 = gn;
      repeat (1500) @(negedge clk);
      wr_en = 1'b0;
      repeat (12) @(negedge clk);
      check(didx - d0 > 256 && !req_ready, "R8 zero count keeps streaming", didx - d0, 257);
      check(gn - g0 == 2 + 2 * (didx - d0), "R8 zero count byte total", gn - g0, 2 + 2 * (didx - d0));
    end
    check_stream("R8 block zero header", 1'b0);
    do_reset();
    wr_en = 1'b1;
    done = 1'b1;
    finish_up();
  end
endmodule